// File: doc/BRIEF.md
# Composite Sync Vertical Extractor with Line-Rate Blank Fill

This block watches a horizontal sync line that may carry composite sync and recovers a separate vertical sync from it. It measures the line period between leading edges of the (polarity-normalized) sync, and treats any active pulse that lasts longer than a programmable fraction of that period as a broad vertical pulse. Detection raises a composite-vertical-present flag at once and, after a fixed extraction delay, drives the extracted vertical sync.

While the extracted vertical sync is high, the horizontal blank output gets synthetic pulses. Each is one eighth of the measured line period wide and repeats at that period, so downstream logic keeps seeing a line rate through the vertical interval. The line period is frozen while a broad pulse interval is being detected, so the half-line pulses of the interval cannot disturb it. A select input lets the extracted sync stand in for a separate vertical sync input on the `vsync_out` pin.

All pins are plain level control and status. There is no data stream, so no valid/ready handshake and no back-pressure apply.

Top module: `csync_separator`

## Requirements
- R1: When `hsync_pol_neg` is 1, a low level on `hsync_raw` is the active sync level; otherwise high is active. With no fill pulse active, `hblank` equals the normalized active level that was driven two clock cycles earlier.
- R2: After at least two leading edges have been measured, an active pulse is broad when it lasts more than P >> FRAC_SHIFT clocks, where P is the latched leading-edge-to-leading-edge period. A pulse whose first active sample is taken at clock edge e0 is detected at edge e0+2+(P >> FRAC_SHIFT). A pulse of exactly P >> FRAC_SHIFT clocks is not broad.
- R3: `cv_vsync` follows the internal detection state exactly DELAY_CYC clocks late, for both rise and fall. Detection clears on the trailing edge of the first active pulse that is not broad.
- R4: A change of the detection state that reverts in fewer than DELAY_CYC clocks never reaches `cv_vsync`.
- R5: `cv_present` rises on the same edge as detection. It falls TIMEOUT_CYC clocks after the last clock in which a broad pulse was seen.
- R6: With `comp_en` low, `cv_present` and the detection state are clear one clock later, and broad pulses are not detected.
- R7: While `cv_vsync` is high and `ins_dis` is low, `hblank` carries pulses P >> 3 clocks wide, repeating every P clocks, with the first starting on the clock that `cv_vsync` rises. P is not updated while detection is active.
- R8: With `ins_dis` high, no fill pulses appear on `hblank`.
- R9: `vsync_out` carries `cv_vsync` when `use_cv` is 1 and `vsync_in` otherwise.
- R10: After reset with positive polarity, `hblank`, `cv_vsync`, `cv_present` and `vsync_out` (with `use_cv` set) are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_raw | input | 1 | Raw horizontal or composite sync line |
| hsync_pol_neg | input | 1 | 1 = sync active low |
| comp_en | input | 1 | Enables composite vertical extraction |
| ins_dis | input | 1 | 1 = suppress blank fill pulses |
| use_cv | input | 1 | Selects extracted sync for `vsync_out` |
| vsync_in | input | 1 | Separate vertical sync input |
| cv_vsync | output | 1 | Extracted vertical sync |
| cv_present | output | 1 | Composite vertical present flag |
| hblank | output | 1 | Normalized sync plus fill pulses |
| vsync_out | output | 1 | Selected vertical sync |

## Verification
Every result has a fixed latency from the first clock edge that samples a stimulus. The normalized sync reaches `hblank` two edges later. Detection and the present flag come 2+(P >> FRAC_SHIFT) edges after a broad pulse starts, and `cv_vsync` comes DELAY_CYC edges after that. The present flag falls TIMEOUT_CYC edges after the last broad cycle, and the enable clears the flag one edge later. The bench drives inputs and samples outputs on falling edges, keeps a cycle counter, and computes each expected event cycle from the stimulus. It samples one cycle before and at that cycle, so an off-by-one latency is reported.

// File: rtl/csync_pkg.sv
package csync_pkg;

  // Normalized sync level plus its edges, one clock after synchronization
  typedef struct packed {
    logic act;
    logic rise;
    logic fall;
  } sync_ev_t;

endpackage

// File: rtl/csync_input.sv
module csync_input (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hs_raw,
  input  logic                 pol_neg,
  output csync_pkg::sync_ev_t  ev
);
  logic [1:0] sy;
  logic       act_q;

  // Two-stage synchronizer; reset to the idle level so no false edge appears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy    <= {2{pol_neg}};
      act_q <= 1'b0;
    end else begin
      sy    <= {sy[0], hs_raw};
      act_q <= ev.act;
    end
  end

  assign ev.act  = sy[1] ^ pol_neg;
  assign ev.rise = ev.act & ~act_q;
  assign ev.fall = ~ev.act & act_q;
endmodule

// File: rtl/csync_meter.sv
module csync_meter #(
  parameter int CNT_W      = 14,
  parameter int FRAC_SHIFT = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  csync_pkg::sync_ev_t  ev,
  output logic [CNT_W-1:0]     per,
  output logic                 wide,
  output logic                 cv_raw
);
  logic [CNT_W-1:0] pc, wc, thr;
  logic             seen, per_ok, pw;

  assign thr  = per >> FRAC_SHIFT;
  assign wide = ev.act & per_ok & (wc >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= '0;
      wc     <= '0;
      per    <= '0;
      seen   <= 1'b0;
      per_ok <= 1'b0;
      pw     <= 1'b0;
      cv_raw <= 1'b0;
    end else begin
      // Leading-edge period, frozen while a vertical interval is detected
      if (ev.rise) begin
        pc <= CNT_W'(1);
        if (!cv_raw) begin
          per  <= pc;
          seen <= 1'b1;
          if (seen) per_ok <= 1'b1;
        end
      end else if (pc != '1) begin
        pc <= pc + 1'b1;
      end

      // Active width of the current pulse
      if (!ev.act)        wc <= '0;
      else if (wc != '1)  wc <= wc + 1'b1;

      // Remember whether the current pulse qualified as broad
      if (wide)          pw <= 1'b1;
      else if (ev.rise)  pw <= 1'b0;

      if (!en)                   cv_raw <= 1'b0;
      else if (wide)             cv_raw <= 1'b1;
      else if (ev.fall && !pw)   cv_raw <= 1'b0;
    end
  end
endmodule

// File: rtl/csync_vs_track.sv
module csync_vs_track #(
  parameter int DELAY_CYC   = 2000,
  parameter int TIMEOUT_CYC = 67_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic wide,
  input  logic cv_raw,
  output logic cv_vs,
  output logic vs_set,
  output logic present
);
  localparam int DW = $clog2(DELAY_CYC + 1);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [DW-1:0] D_LAST = DW'(DELAY_CYC - 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYC - 1);

  logic [DW-1:0] dcnt;
  logic [TW-1:0] tcnt;

  assign vs_set = cv_raw & ~cv_vs & (dcnt == D_LAST);

  // Output takes a new level only after it has held for DELAY_CYC clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt  <= '0;
      cv_vs <= 1'b0;
    end else if (cv_raw != cv_vs) begin
      if (dcnt == D_LAST) begin
        cv_vs <= cv_raw;
        dcnt  <= '0;
      end else begin
        dcnt <= dcnt + 1'b1;
      end
    end else begin
      dcnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= 1'b0;
      tcnt    <= '0;
    end else if (!en) begin
      present <= 1'b0;
      tcnt    <= '0;
    end else if (wide) begin
      present <= 1'b1;
      tcnt    <= '0;
    end else if (tcnt == T_LAST) begin
      present <= 1'b0;
    end else begin
      tcnt <= tcnt + 1'b1;
    end
  end
endmodule

// File: rtl/csync_fill.sv
module csync_fill #(
  parameter int CNT_W      = 14,
  parameter int FILL_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cv_vs,
  input  logic             vs_set,
  input  logic             ins_dis,
  input  logic             act,
  input  logic [CNT_W-1:0] per,
  output logic             hblank
);
  logic [CNT_W-1:0] lt, lt_nxt, fill_w;
  logic             ins;

  assign lt_nxt = lt + 1'b1;
  assign fill_w = per >> FILL_SHIFT;

  // Line-phase timer restarted when extracted sync rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                lt <= '0;
    else if (vs_set || !cv_vs || lt_nxt >= per) lt <= '0;
    else                                       lt <= lt_nxt;
  end

  assign ins    = cv_vs & ~ins_dis & (lt < fill_w);
  assign hblank = act | ins;
endmodule

// File: rtl/csync_separator.sv
module csync_separator #(
  parameter int CNT_W       = 14,
  parameter int FRAC_SHIFT  = 1,
  parameter int FILL_SHIFT  = 3,
  parameter int DELAY_CYC   = 2000,
  parameter int TIMEOUT_CYC = 67_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hsync_raw,
  input  logic hsync_pol_neg,
  input  logic comp_en,
  input  logic ins_dis,
  input  logic use_cv,
  input  logic vsync_in,
  output logic cv_vsync,
  output logic cv_present,
  output logic hblank,
  output logic vsync_out
);
  csync_pkg::sync_ev_t ev;
  logic [CNT_W-1:0]    per_lat;
  logic                wide, cv_raw, vs_set;

  csync_input u_in (
    .clk(clk), .rst_n(rst_n), .hs_raw(hsync_raw), .pol_neg(hsync_pol_neg), .ev(ev)
  );

  csync_meter #(.CNT_W(CNT_W), .FRAC_SHIFT(FRAC_SHIFT)) u_meter (
    .clk(clk), .rst_n(rst_n), .en(comp_en), .ev(ev),
    .per(per_lat), .wide(wide), .cv_raw(cv_raw)
  );

  csync_vs_track #(.DELAY_CYC(DELAY_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_track (
    .clk(clk), .rst_n(rst_n), .en(comp_en), .wide(wide), .cv_raw(cv_raw),
    .cv_vs(cv_vsync), .vs_set(vs_set), .present(cv_present)
  );

  csync_fill #(.CNT_W(CNT_W), .FILL_SHIFT(FILL_SHIFT)) u_fill (
    .clk(clk), .rst_n(rst_n), .cv_vs(cv_vsync), .vs_set(vs_set),
    .ins_dis(ins_dis), .act(ev.act), .per(per_lat), .hblank(hblank)
  );

  assign vsync_out = use_cv ? cv_vsync : vsync_in;
endmodule

// File: rtl/csync_separator_chk.sv
module csync_separator_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             comp_en,
  input logic             ins_dis,
  input logic             hblank,
  input logic             cv_vsync,
  input logic             cv_present,
  input logic             act,
  input logic             cv_raw,
  input logic [CNT_W-1:0] per
);
  // R2: detection only ever starts during an active sync pulse
  p_det_in_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cv_raw) |-> $past(act));

  // R3: extracted sync moves only toward the detection level
  p_vs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cv_vsync) |-> $past(cv_raw));
  p_vs_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cv_vsync) |-> !$past(cv_raw));

  // R5: present flag rises together with detection
  p_pres_det_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cv_present) |-> cv_raw);

  // R6: disabling clears present and detection on the next clock
  p_en_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !comp_en |=> (!cv_present && !cv_raw));

  // R7: line period held while detection persists
  p_per_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_raw && $past(cv_raw)) |-> $stable(per));

  // R8: blank beyond the sync itself needs extracted sync and fill enabled
  p_ins_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank && !act) |-> (cv_vsync && !ins_dis));
endmodule

bind csync_separator csync_separator_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .comp_en(comp_en), .ins_dis(ins_dis),
  .hblank(hblank), .cv_vsync(cv_vsync), .cv_present(cv_present),
  .act(ev.act), .cv_raw(cv_raw), .per(per_lat)
);

// File: tb/sim_csync_separator.sv
`timescale 1ns/1ps
module sim_csync_separator;
  localparam int DLY = 40;
  localparam int TMO = 3000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hs = 1'b0, pol = 1'b0, en = 1'b0, idis = 1'b0, ucv = 1'b0, vin = 1'b0;
  logic cv_vsync, cv_present, hblank, vsync_out;

  int cyc = 0, checks = 0, fails = 0;
  int pres_rise = -1;
  logic pres_q = 1'b0, mclr = 1'b1;
  int e0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  csync_separator #(.CNT_W(12), .FRAC_SHIFT(1), .FILL_SHIFT(3),
                    .DELAY_CYC(DLY), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .hsync_raw(hs), .hsync_pol_neg(pol),
    .comp_en(en), .ins_dis(idis), .use_cv(ucv), .vsync_in(vin),
    .cv_vsync(cv_vsync), .cv_present(cv_present), .hblank(hblank),
    .vsync_out(vsync_out)
  );

  // Output monitor: first rise of the present flag since the last clear
  always @(negedge clk) begin
    if (mclr) begin
      pres_rise = -1;
      pres_q    = 1'b0;
    end else begin
      if (cv_present && !pres_q && pres_rise < 0) pres_rise = cyc;
      pres_q = cv_present;
    end
  end

  function automatic bit fill_exp(int j, int p);
    return (j % p) < (p >> 3);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic put(input bit a);
    @(negedge clk);
    hs = a ^ pol;
  endtask

  task automatic line(input int w, input int p);
    for (int i = 0; i < p; i++) put(i < w);
  endtask

  task automatic broad(input int w);
    for (int i = 0; i < w; i++) begin
      put(1'b1);
      if (i == 0) e0 = cyc + 1;
    end
    put(1'b0);
  endtask

  task automatic wait_to(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; mclr = 1'b1; hs = pol;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; mclr = 1'b0;
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r, p, w, thr, z, f0, y;
    bit a1, a2, seen;
    r = $urandom(32'h5eed);

    // R10: reset state
    pol = 0; en = 1; ucv = 1; vin = 0;
    do_reset();
    chk(hblank == 0,     "R10 hblank",    hblank, 0);
    chk(cv_vsync == 0,   "R10 cv_vsync",  cv_vsync, 0);
    chk(cv_present == 0, "R10 present",   cv_present, 0);
    chk(vsync_out == 0,  "R10 vsync_out", vsync_out, 0);

    // R1: random sync levels, both polarities, two-cycle lag, extraction off
    for (int s = 0; s < 2; s++) begin
      pol = s[0]; en = 0;
      do_reset();
      a1 = 0; a2 = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        chk(hblank == a2, "R1 hblank lag", hblank, a2);
        a2 = a1;
        a1 = $urandom % 2;
        hs = a1 ^ pol;
      end
    end

    // R2: boundary, width equal to threshold is not broad; one more is
    pol = 0; en = 1; idis = 0;
    do_reset();
    repeat (3) line(4, 64);
    line(32, 64);
    line(4, 64);
    chk(pres_rise == -1, "R2 width at threshold", pres_rise, -1);
    broad(33);
    repeat (6) @(negedge clk);
    chk(pres_rise == e0 + 34, "R2 threshold+1 detect", pres_rise, e0 + 34);

    // R2 R3 R5 R7 R8 R9: constrained random line periods
    for (int it = 0; it < 6; it++) begin
      p = 48 + int'($urandom % 113);
      thr = p >> 1;
      w = thr + 1 + int'($urandom % 8);
      pol = $urandom % 2; ucv = $urandom % 2; vin = $urandom % 2;
      en = 1; idis = 0;
      do_reset();
      repeat (3) line(2 + int'($urandom % 5), p);
      broad(w);
      z = e0 + 2 + thr + DLY;
      wait_to(z - 1);
      chk(cv_vsync == 0, "R3 vsync before delay", cv_vsync, 0);
      chk(pres_rise == e0 + 2 + thr, "R5 present rise", pres_rise, e0 + 2 + thr);
      for (int j = 0; j < 3 * p; j++) begin
        wait_to(z + j);
        if (j == 0) begin
          chk(cv_vsync == 1, "R3 vsync at delay", cv_vsync, 1);
          chk(vsync_out == (ucv ? 1'b1 : vin), "R9 vsync select", vsync_out, ucv ? 1 : int'(vin));
        end
        chk(hblank == fill_exp(j, p), "R7 fill pattern", hblank, fill_exp(j, p));
      end
      @(negedge clk); idis = 1;
      for (int j = 0; j < p; j++) begin
        @(negedge clk);
        chk(hblank == 0, "R8 fill disabled", hblank, 0);
      end
      idis = 0;
      for (int i = 0; i < 4; i++) put(1'b1);
      put(1'b0);
      f0 = cyc + 1;
      wait_to(f0 + 1 + DLY);
      chk(cv_vsync == 1, "R3 vsync before fall", cv_vsync, 1);
      @(negedge clk);
      chk(cv_vsync == 0, "R3 vsync fall", cv_vsync, 0);
    end

    // R4: detection that reverts within the delay is filtered
    pol = 0; ucv = 1; en = 1;
    do_reset();
    repeat (3) line(4, 64);
    line(40, 64);
    line(4, 64);
    seen = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      seen = seen | cv_vsync;
    end
    chk(seen == 0, "R4 short detection filtered", seen, 0);

    // R5: present timeout after last broad cycle
    do_reset();
    repeat (3) line(4, 64);
    broad(40);
    y = e0 + 1 + 40;
    wait_to(y + TMO - 1);
    chk(cv_present == 1, "R5 present before timeout", cv_present, 1);
    @(negedge clk);
    chk(cv_present == 0, "R5 present after timeout", cv_present, 0);

    // R6: enable low clears next clock and blocks detection
    do_reset();
    repeat (3) line(4, 64);
    broad(40);
    wait_to(e0 + 45);
    chk(cv_present == 1, "R6 present while enabled", cv_present, 1);
    en = 0;
    @(negedge clk);
    chk(cv_present == 0, "R6 present cleared", cv_present, 0);
    repeat (3) line(4, 64);
    broad(40);
    seen = 0;
    for (int i = 0; i < DLY + 60; i++) begin
      @(negedge clk);
      seen = seen | cv_present | cv_vsync;
    end
    chk(seen == 0, "R6 no detection when disabled", seen, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule